// File: doc/BRIEF.md
# Compare-and-Branch Resolver with Static Prediction

This block settles the outcome of conditional branches that compare two signed words, and of short branches that test the stack top against an immediate byte. Each instruction carries a static guess, one opcode bit, about whether the branch will be taken. The block works out the real outcome and the next fetch address. When the guess was wrong, it requests a fetch redirect and reports the bubble that the miss costs.

The block takes one instruction per cycle while `ins_valid` is high. Its registered results show up one clock edge later. The operand words come from outside: the stack top, the two constant registers and the B word. The block only chooses among them and compares them. Four saturating counters record how well the static guesses work, so that code layout can be tuned later.

Top module: `cmp_branch_resolver`

## Requirements
- R1: While `rst` is high at a rising edge, `next_pc`, `redirect`, `penalty`, `pop` and all four counters become zero.
- R2: In register mode (`imm_mode`=0), `a_sel` picks the A operand: 0 selects `const0_word`, 1 selects `const1_word`, 2 selects `stack_top`, and 3 selects `stack_top` and also pops it.
- R3: In register mode, the condition is a signed 32-bit comparison of A with `b_word`. The `cond` codes are 0 equal, 1 greater, 2 greater-or-equal, 3 less, 4 less-or-equal and 5 not-equal. Codes 6 and 7 are never taken.
- R4: A taken branch sets `next_pc` to `pc` plus the sign-extended `disp` byte. Byte values 128 to 255 count as negative.
- R5: A branch that is not taken sets `next_pc` to `pc` + 3, which is the instruction length.
- R6: When the outcome matches `pred_taken`, `redirect` stays low and `penalty` is 0.
- R7: When the outcome differs from `pred_taken`, in either direction, `redirect` is high for exactly one cycle and `penalty` is 3 in that same cycle.
- R8: `pop` pulses for one cycle alongside the result when register mode uses `a_sel`=3, and for every immediate-mode branch.
- R9: In immediate mode (`imm_mode`=1), `stack_top` is compared with `imm_byte` zero-extended to 32 bits. A `cond` of 5 means not-equal and any other code means equal. `b_word` and `a_sel` have no effect in this mode.
- R10: Each resolved branch adds one to exactly one counter. The four cases are taken and guessed taken, taken but guessed not taken, not taken and guessed not taken, and not taken but guessed taken.
- R11: The counters are 16 bits wide and stay at 65535 once they reach it.
- R12: Results are due one edge after `ins_valid`. In a cycle without `ins_valid`, `next_pc` holds its value and `redirect`, `pop` and `penalty` return to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ins_valid | input | 1 | A branch is presented this cycle |
| pc | input | 32 | Address of the branch instruction |
| a_sel | input | 2 | A-operand choice in register mode |
| stack_top | input | 32 | Current stack-top word |
| const0_word | input | 32 | Constant register 0 |
| const1_word | input | 32 | Constant register 1 |
| b_word | input | 32 | B operand for register compares |
| cond | input | 3 | Condition code |
| imm_mode | input | 1 | 1 selects the immediate-byte compare |
| pred_taken | input | 1 | Static guess carried in the opcode |
| disp | input | 8 | Signed branch displacement |
| imm_byte | input | 8 | Immediate byte for immediate mode |
| next_pc | output | 32 | Resolved next fetch address |
| redirect | output | 1 | One-cycle fetch redirect on a miss |
| penalty | output | 2 | Extra cycles charged for this branch |
| pop | output | 1 | Stack-top pop pulse |
| cnt_taken_hit | output | 16 | Taken and guessed taken |
| cnt_taken_miss | output | 16 | Taken but guessed not taken |
| cnt_fall_hit | output | 16 | Not taken and guessed not taken |
| cnt_fall_miss | output | 16 | Not taken but guessed taken |

## Verification
Every result of a branch presented at one rising edge is registered at that edge: the next PC, the redirect strobe, the penalty, the pop pulse and the counter increment. The bench therefore drives each branch at a falling edge, lets one rising edge pass, and samples at the following falling edge. After a miss it waits one more edge to check that the redirect and penalty have dropped back to zero. The counters are compared with a model kept in the bench. Saturation is reached with an unbroken run of more than 65535 branches.

// File: rtl/cbr_pkg.sv
package cbr_pkg;

    localparam int DATA_W    = 32;
    localparam int CNT_W     = 16;
    localparam int INSN_LEN  = 3;
    localparam int MISS_COST = 3;

    typedef enum logic [1:0] {
        ASEL_C0   = 2'd0,
        ASEL_C1   = 2'd1,
        ASEL_TOP  = 2'd2,
        ASEL_POP  = 2'd3
    } asel_e;

    typedef enum logic [2:0] {
        CND_EQ = 3'd0,
        CND_GT = 3'd1,
        CND_GE = 3'd2,
        CND_LT = 3'd3,
        CND_LE = 3'd4,
        CND_NE = 3'd5
    } cond_e;

    // Class index used by the statistics counters
    typedef enum logic [1:0] {
        CLS_TAKEN_HIT  = 2'd0,
        CLS_TAKEN_MISS = 2'd1,
        CLS_FALL_HIT   = 2'd2,
        CLS_FALL_MISS  = 2'd3
    } outcome_cls_e;

    typedef struct packed {
        logic [DATA_W-1:0] a_word;
        logic              do_pop;
    } operand_t;

    typedef struct packed {
        logic taken;
        logic guess;
    } outcome_t;

    function automatic logic [DATA_W-1:0] sext8(input logic [7:0] b);
        return {{(DATA_W-8){b[7]}}, b};
    endfunction

    function automatic logic [DATA_W-1:0] zext8(input logic [7:0] b);
        return {{(DATA_W-8){1'b0}}, b};
    endfunction

    function automatic outcome_cls_e classify(input outcome_t o);
        return outcome_cls_e'({~o.taken, o.taken ^ o.guess});
    endfunction

endpackage

// File: rtl/cbr_operand_sel.sv
module cbr_operand_sel
    import cbr_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic [1:0]   a_sel,
    input  logic         imm_mode,
    input  logic [W-1:0] stack_top,
    input  logic [W-1:0] const0_word,
    input  logic [W-1:0] const1_word,
    output logic [W-1:0] a_word,
    output logic         do_pop
);
    always_comb begin
        a_word = stack_top;
        do_pop = 1'b0;
        if (imm_mode) begin
            a_word = stack_top;
            do_pop = 1'b1;
        end else begin
            unique case (asel_e'(a_sel))
                ASEL_C0:  a_word = const0_word;
                ASEL_C1:  a_word = const1_word;
                ASEL_TOP: a_word = stack_top;
                ASEL_POP: begin
                    a_word = stack_top;
                    do_pop = 1'b1;
                end
                default:  a_word = stack_top;
            endcase
        end
    end
endmodule

// File: rtl/cbr_cond_eval.sv
module cbr_cond_eval
    import cbr_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic [W-1:0] a_word,
    input  logic [W-1:0] b_word,
    input  logic [7:0]   imm_byte,
    input  logic         imm_mode,
    input  logic [2:0]   cond,
    output logic         taken
);
    logic [W-1:0] rhs;
    logic         eq, lt;

    assign rhs = imm_mode ? zext8(imm_byte) : b_word;
    assign eq  = (a_word == rhs);
    assign lt  = ($signed(a_word) < $signed(rhs));

    always_comb begin
        if (imm_mode) begin
            taken = (cond_e'(cond) == CND_NE) ? !eq : eq;
        end else begin
            unique case (cond)
                CND_EQ:  taken = eq;
                CND_GT:  taken = !eq && !lt;
                CND_GE:  taken = !lt;
                CND_LT:  taken = lt;
                CND_LE:  taken = lt || eq;
                CND_NE:  taken = !eq;
                default: taken = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/cbr_outcome_stats.sv
module cbr_outcome_stats
    import cbr_pkg::*;
#(
    parameter int CW = CNT_W,
    parameter int NCLS = 4
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   ev_valid,
    input  outcome_t               ev,
    output logic [NCLS-1:0][CW-1:0] counts
);
    localparam logic [CW-1:0] SAT = {CW{1'b1}};

    outcome_cls_e cls;
    assign cls = classify(ev);

    for (genvar i = 0; i < NCLS; i++) begin : g_cnt
        logic hit;
        assign hit = ev_valid && (int'(cls) == i);

        always_ff @(posedge clk) begin
            if (rst)
                counts[i] <= '0;
            else if (hit && counts[i] != SAT)
                counts[i] <= counts[i] + 1'b1;
        end

        // R10
        cnt_monotone_chk: assert property (@(posedge clk) disable iff (rst)
            counts[i] >= $past(counts[i]));

        // R11
        cnt_saturate_chk: assert property (@(posedge clk) disable iff (rst)
            ($past(counts[i]) == SAT) |-> (counts[i] == SAT));
    end
endmodule

// File: rtl/cmp_branch_resolver.sv
module cmp_branch_resolver
    import cbr_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        ins_valid,
    input  logic [31:0] pc,
    input  logic [1:0]  a_sel,
    input  logic [31:0] stack_top,
    input  logic [31:0] const0_word,
    input  logic [31:0] const1_word,
    input  logic [31:0] b_word,
    input  logic [2:0]  cond,
    input  logic        imm_mode,
    input  logic        pred_taken,
    input  logic [7:0]  disp,
    input  logic [7:0]  imm_byte,
    output logic [31:0] next_pc,
    output logic        redirect,
    output logic [1:0]  penalty,
    output logic        pop,
    output logic [15:0] cnt_taken_hit,
    output logic [15:0] cnt_taken_miss,
    output logic [15:0] cnt_fall_hit,
    output logic [15:0] cnt_fall_miss
);
    localparam int PEN_W = $clog2(MISS_COST + 1);
    localparam logic [PEN_W-1:0] MISS_PEN = PEN_W'(MISS_COST);
    localparam logic [DATA_W-1:0] STEP = DATA_W'(INSN_LEN);

    operand_t              opnd;
    outcome_t              oc;
    logic [DATA_W-1:0]     target, fall_pc;
    logic [3:0][CNT_W-1:0] counts;

    cbr_operand_sel #(.W(DATA_W)) u_sel (
        .a_sel       (a_sel),
        .imm_mode    (imm_mode),
        .stack_top   (stack_top),
        .const0_word (const0_word),
        .const1_word (const1_word),
        .a_word      (opnd.a_word),
        .do_pop      (opnd.do_pop)
    );

    cbr_cond_eval #(.W(DATA_W)) u_cond (
        .a_word   (opnd.a_word),
        .b_word   (b_word),
        .imm_byte (imm_byte),
        .imm_mode (imm_mode),
        .cond     (cond),
        .taken    (oc.taken)
    );

    assign oc.guess = pred_taken;
    assign target   = pc + sext8(disp);
    assign fall_pc  = pc + STEP;

    always_ff @(posedge clk) begin
        if (rst) begin
            next_pc  <= '0;
            redirect <= 1'b0;
            penalty  <= '0;
            pop      <= 1'b0;
        end else if (ins_valid) begin
            next_pc  <= oc.taken ? target : fall_pc;
            redirect <= oc.taken ^ oc.guess;
            penalty  <= (oc.taken ^ oc.guess) ? MISS_PEN : '0;
            pop      <= opnd.do_pop;
        end else begin
            redirect <= 1'b0;
            penalty  <= '0;
            pop      <= 1'b0;
        end
    end

    cbr_outcome_stats #(.CW(CNT_W), .NCLS(4)) u_stats (
        .clk      (clk),
        .rst      (rst),
        .ev_valid (ins_valid),
        .ev       (oc),
        .counts   (counts)
    );

    assign cnt_taken_hit  = counts[CLS_TAKEN_HIT];
    assign cnt_taken_miss = counts[CLS_TAKEN_MISS];
    assign cnt_fall_hit   = counts[CLS_FALL_HIT];
    assign cnt_fall_miss  = counts[CLS_FALL_MISS];

    // R7
    miss_penalty_chk: assert property (@(posedge clk) disable iff (rst)
        redirect |-> (penalty == MISS_PEN));

    // R6
    hit_free_chk: assert property (@(posedge clk) disable iff (rst)
        !redirect |-> (penalty == '0));

    // R8
    pop_origin_chk: assert property (@(posedge clk) disable iff (rst)
        pop |-> $past(ins_valid));

    // R12
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(ins_valid) |-> ($stable(next_pc) && !redirect));
endmodule

// File: tb/cmp_branch_resolver_tb_top.sv
module cmp_branch_resolver_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        ins_valid;
    logic [31:0] pc, stack_top, const0_word, const1_word, b_word;
    logic [1:0]  a_sel;
    logic [2:0]  cond;
    logic        imm_mode, pred_taken;
    logic [7:0]  disp, imm_byte;
    logic [31:0] next_pc;
    logic        redirect, pop;
    logic [1:0]  penalty;
    logic [15:0] cnt_taken_hit, cnt_taken_miss, cnt_fall_hit, cnt_fall_miss;

    int checks = 0;
    int failures = 0;
    int exp_cnt[4];
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cmp_branch_resolver dut_i (
        .clk(clk), .rst(rst), .ins_valid(ins_valid), .pc(pc), .a_sel(a_sel),
        .stack_top(stack_top), .const0_word(const0_word), .const1_word(const1_word),
        .b_word(b_word), .cond(cond), .imm_mode(imm_mode), .pred_taken(pred_taken),
        .disp(disp), .imm_byte(imm_byte), .next_pc(next_pc), .redirect(redirect),
        .penalty(penalty), .pop(pop), .cnt_taken_hit(cnt_taken_hit),
        .cnt_taken_miss(cnt_taken_miss), .cnt_fall_hit(cnt_fall_hit),
        .cnt_fall_miss(cnt_fall_miss)
    );

    task automatic check(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Independent model of the outcome
    function automatic bit model_taken(input bit im, input logic [1:0] s, input logic [2:0] c,
                                       input logic [31:0] top, input logic [31:0] k0,
                                       input logic [31:0] k1, input logic [31:0] b,
                                       input logic [7:0] ib);
        longint a, r;
        if (im) begin
            if (c == 3'd5) return top != {24'd0, ib};
            return top == {24'd0, ib};
        end
        a = (s == 2'd0) ? longint'($signed(k0)) : (s == 2'd1) ? longint'($signed(k1))
                                                             : longint'($signed(top));
        r = longint'($signed(b));
        case (c)
            3'd0: return a == r;
            3'd1: return a > r;
            3'd2: return a >= r;
            3'd3: return a < r;
            3'd4: return a <= r;
            3'd5: return a != r;
            default: return 0;
        endcase
    endfunction

    function automatic void bump(input bit tk, input bit pr);
        int idx = tk ? (pr ? 0 : 1) : (pr ? 3 : 2);
        if (exp_cnt[idx] < 65535) exp_cnt[idx]++;
    endfunction

    task automatic check_counts(input string req);
        check(req, "cnt_taken_hit", cnt_taken_hit, exp_cnt[0]);
        check(req, "cnt_taken_miss", cnt_taken_miss, exp_cnt[1]);
        check(req, "cnt_fall_hit", cnt_fall_hit, exp_cnt[2]);
        check(req, "cnt_fall_miss", cnt_fall_miss, exp_cnt[3]);
    endtask

    // Presents one branch at a falling edge, samples at the next falling edge
    task automatic issue(input string req, input bit im, input logic [1:0] s, input logic [2:0] c,
                         input logic [31:0] top, input logic [31:0] b, input logic [7:0] ib,
                         input logic [31:0] p, input logic [7:0] d, input bit pr);
        bit tk;
        logic [31:0] exp_pc;
        ins_valid = 1; imm_mode = im; a_sel = s; cond = c; stack_top = top;
        b_word = b; imm_byte = ib; pc = p; disp = d; pred_taken = pr;
        tk = model_taken(im, s, c, top, const0_word, const1_word, b, ib);
        exp_pc = tk ? p + {{24{d[7]}}, d} : p + 32'd3;
        bump(tk, pr);
        @(negedge clk);
        ins_valid = 0;
        check(req, "next_pc", next_pc, exp_pc);
        check(req, "redirect", redirect, tk != pr);
        check(req, "penalty", penalty, (tk != pr) ? 3 : 0);
        check(req, "pop", pop, im || (s == 2'd3));
    endtask

    task automatic t_reset;
        check("R1", "next_pc", next_pc, 0);
        check("R1", "redirect", redirect, 0);
        check("R1", "penalty", penalty, 0);
        check("R1", "pop", pop, 0);
        check_counts("R1");
    endtask

    task automatic t_operand_select;
        // const0=5, const1=-7, top=100, b=5 equal only for sel 0
        issue("R2", 0, 2'd0, 3'd0, 32'd100, 32'd5, 8'd0, 32'h1000, 8'h10, 1);
        issue("R2", 0, 2'd1, 3'd3, 32'd100, 32'd5, 8'd0, 32'h1000, 8'h10, 1);
        issue("R2", 0, 2'd2, 3'd1, 32'd100, 32'd5, 8'd0, 32'h1000, 8'h10, 0);
        issue("R2", 0, 2'd3, 3'd0, 32'd100, 32'd5, 8'd0, 32'h1000, 8'h10, 0);
    endtask

    task automatic t_conditions;
        for (int c = 0; c < 8; c++) begin
            issue("R3", 0, 2'd2, 3'(c), 32'hFFFF_FFFE, 32'd3, 8'd0, 32'h2000, 8'h08, 1);
            issue("R3", 0, 2'd2, 3'(c), 32'd3, 32'hFFFF_FFFE, 8'd0, 32'h2000, 8'h08, 0);
            issue("R3", 0, 2'd2, 3'(c), 32'h8000_0000, 32'h8000_0000, 8'd0, 32'h2000, 8'h08, 1);
        end
    endtask

    task automatic t_displacement;
        issue("R4", 0, 2'd2, 3'd0, 32'd9, 32'd9, 8'd0, 32'h3000, 8'h7F, 1);
        issue("R4", 0, 2'd2, 3'd0, 32'd9, 32'd9, 8'd0, 32'h3000, 8'h80, 1);
        issue("R4", 0, 2'd2, 3'd0, 32'd9, 32'd9, 8'd0, 32'h0000_0010, 8'hFF, 1);
        issue("R5", 0, 2'd2, 3'd5, 32'd9, 32'd9, 8'd0, 32'hFFFF_FFFE, 8'h80, 0);
    endtask

    task automatic t_mispredict;
        issue("R7", 0, 2'd2, 3'd0, 32'd1, 32'd1, 8'd0, 32'h4000, 8'h20, 0);
        @(negedge clk);
        check("R7", "redirect drop", redirect, 0);
        check("R7", "penalty drop", penalty, 0);
        issue("R7", 0, 2'd2, 3'd0, 32'd1, 32'd2, 8'd0, 32'h4000, 8'h20, 1);
        issue("R6", 0, 2'd2, 3'd0, 32'd1, 32'd2, 8'd0, 32'h4000, 8'h20, 0);
    endtask

    task automatic t_immediate;
        issue("R9", 1, 2'd0, 3'd0, 32'h0000_00FF, 32'h1234, 8'hFF, 32'h5000, 8'h04, 1);
        issue("R9", 1, 2'd1, 3'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 8'hFF, 32'h5000, 8'h04, 1);
        issue("R9", 1, 2'd0, 3'd5, 32'hFFFF_FFFF, 32'd0, 8'hFF, 32'h5000, 8'hFC, 1);
        issue("R8", 1, 2'd0, 3'd5, 32'd7, 32'd0, 8'd7, 32'h5000, 8'hFC, 0);
    endtask

    task automatic t_idle;
        logic [31:0] held = next_pc;
        pc = 32'hDEAD_0000; disp = 8'h55;
        repeat (3) @(negedge clk);
        check("R12", "next_pc held", next_pc, held);
        check("R12", "pop idle", pop, 0);
        check("R12", "redirect idle", redirect, 0);
        check_counts("R10");
    endtask

    task automatic t_saturate;
        ins_valid = 1; imm_mode = 0; a_sel = 2'd2; cond = 3'd0; stack_top = 32'd4;
        b_word = 32'd4; pc = 32'h6000; disp = 8'h02; pred_taken = 1;
        for (int i = 0; i < 65540; i++) bump(1, 1);
        repeat (65540) @(negedge clk);
        ins_valid = 0;
        @(negedge clk);
        check_counts("R11");
        check("R11", "cnt_taken_hit sat", cnt_taken_hit, 65535);
    endtask

    initial begin
        rst = 1; ins_valid = 0; pc = 0; a_sel = 0; stack_top = 0; b_word = 0;
        const0_word = 32'd5; const1_word = 32'hFFFF_FFF9; cond = 0; imm_mode = 0;
        pred_taken = 0; disp = 0; imm_byte = 0;
        repeat (3) @(negedge clk);
        t_reset();
        rst = 0;
        @(negedge clk);
        t_operand_select();
        t_conditions();
        t_displacement();
        t_mispredict();
        t_immediate();
        t_idle();
        t_saturate();
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                failures++;
                checks++;
                $display("FAIL watchdog expired actual=running expected=finished");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule